// File: doc/BRIEF.md
# Compare-Match System Timer with Access Handshake

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on every cycle in which the timer tick strobe is high and the run bit is set. It wraps silently from all ones to zero. A single compare register raises a status flag when the count becomes equal to it. An enable bit gates that flag onto a registered interrupt line. The flag stays set until software clears it by writing a one to it.

Software does not read the live counter. It writes the latch request to the control register and polls the access-status register until the snapshot-busy bit drops. It then reads the snapshot through the count offset. Writes to the compare and count registers are staged in the same way. Each write raises its own busy bit for `SYNC_DEPTH` clocks before it takes effect, which models the crossing into a slower timer domain. Software waits for a busy bit to clear before it issues the next write of that kind.

The bus side is a plain single-cycle write strobe and a read strobe. Read data is registered and valid on the clock after the read strobe.

Top module: `match_timer`

## Requirements
- R1: After reset, reads return compare = 0xFFFFFFFF, count snapshot = 0, status = 0, enable = 0, control = 0 and access status = 0, and `irq` is low.
- R2: Control offset 0x20, bit 0 (run): while this bit is set, the counter advances by one on each clock with `tick_en` high. While it is clear, the counter holds. Reading control returns the run bit in bit 0, and bit 1 always reads as zero.
- R3: Writing control with bit 1 set requests a snapshot. Access-status bit 5 reads 1 for `SYNC_DEPTH` clocks, and the counter value is then captured. Reading offset 0x10 returns the last captured snapshot, never the live count.
- R4: A write to offset 0x10 sets access-status bit 4 for `SYNC_DEPTH` clocks, after which the counter is loaded with the written value.
- R5: A write to compare offset 0x00 sets access-status bit 0 for `SYNC_DEPTH` clocks. Until that bit clears, reads of 0x00 return the previous compare value; the new value is then committed. A second write while the bit is set replaces the staged value and restarts the wait.
- R6: Status offset 0x14, bit 0 is set when the counter becomes equal to the compare value. Status bits 3:1 always read as zero.
- R7: Writing status clears each bit written as 1, and bits written as 0 are left unchanged. A match and a clear in the same cycle leave the bit set.
- R8: Enable offset 0x1C, bit 0 gates the interrupt. `irq` is the registered AND of status bit 0 and enable bit 0, so it follows either of them one clock later.
- R9: The counter wraps from 0xFFFFFFFF to 0 with no flag unless the compare value is 0.
- R10: A read of any offset other than 0x00, 0x10, 0x14, 0x1C, 0x20 or 0x24 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick strobe (one pulse per 3 MHz period) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the clock after `rd_en` |
| irq | output | 1 | Compare-match interrupt, level |

## Verification
The bench reads the compare register while its write is still pending. A design that committed at once would return the new value too early. It takes two snapshots around a series of ticks and checks that the count offset holds the stale value between requests. A design that returned the live counter would fail that check. The bench loads 0xFFFFFFFE with a compare of 5 to prove that a wrap neither sets the flag nor stops the count. It also checks that a status write of zero does not clear the flag, that a set flag with the enable off keeps `irq` low, and that writing control with only bit 1 set stops the counter.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ACC  = 6'h24;
  // access-status bit positions, software polls these
  localparam int ACC_CMP_BIT  = 0;
  localparam int ACC_CNT_BIT  = 4;
  localparam int ACC_SNAP_BIT = 5;
  // index of each staged channel in the busy tracker array
  localparam int CH_CMP  = 0;
  localparam int CH_CNT  = 1;
  localparam int CH_SNAP = 2;
  localparam int NUM_CH  = 3;
endpackage

// File: rtl/match_timer_busy.sv
module match_timer_busy #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LOAD = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)              left_q <= '0;
    else if (start)       left_q <= LOAD;
    else if (left_q != 0) left_q <= left_q - ONE;
  end

  assign busy = (left_q != '0);
  assign done = (left_q == ONE) && !start;
endmodule

// File: rtl/match_timer_counter.sv
module match_timer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (run && tick) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/match_timer_cmp.sv
module match_timer_cmp #(
  parameter int W  = 32,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  cnt,
  input  logic [W-1:0]  cmp_val,
  input  logic [SW-1:0] clr,
  output logic [SW-1:0] status
);
  logic eq_q;
  logic hit;

  assign hit = (cnt == cmp_val) && !eq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_q   <= 1'b0;
      status <= '0;
    end else begin
      eq_q      <= (cnt == cmp_val);
      status[0] <= hit | (status[0] & ~clr[0]);
      status[SW-1:1] <= '0;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int CW         = 32,
  parameter int SYNC_DEPTH = 3,
  parameter int STAT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic              irq
);
  logic [NUM_CH-1:0] ch_start, ch_busy, ch_done;
  logic [CW-1:0]     cmp_q, cmp_pend, cnt_pend, cnt_q, snap_q;
  logic              run_q, ien_q;
  logic [STAT_W-1:0] status, stat_clr;
  logic [CW-1:0]     acc_vec;

  assign ch_start[CH_CMP]  = wr_en && (addr == OFS_CMP);
  assign ch_start[CH_CNT]  = wr_en && (addr == OFS_CNT);
  assign ch_start[CH_SNAP] = wr_en && (addr == OFS_CTL) && wdata[1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_busy
    match_timer_busy #(.DEPTH(SYNC_DEPTH)) u_busy (
      .clk(clk), .rst(rst), .start(ch_start[g]),
      .busy(ch_busy[g]), .done(ch_done[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q    <= '1;
      cmp_pend <= '1;
      cnt_pend <= '0;
      snap_q   <= '0;
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (ch_start[CH_CMP]) cmp_pend <= wdata;
      if (ch_start[CH_CNT]) cnt_pend <= wdata;
      if (ch_done[CH_CMP])  cmp_q    <= cmp_pend;
      if (ch_done[CH_SNAP]) snap_q   <= cnt_q;
      if (wr_en && addr == OFS_CTL) run_q <= wdata[0];
      if (wr_en && addr == OFS_IEN) ien_q <= wdata[0];
    end
  end

  match_timer_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick_en),
    .load(ch_done[CH_CNT]), .load_val(cnt_pend), .cnt(cnt_q)
  );

  assign stat_clr = (wr_en && addr == OFS_STAT) ? wdata[STAT_W-1:0] : '0;

  match_timer_cmp #(.W(CW), .SW(STAT_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt_q), .cmp_val(cmp_q),
    .clr(stat_clr), .status(status)
  );

  always_comb begin
    acc_vec               = '0;
    acc_vec[ACC_CMP_BIT]  = ch_busy[CH_CMP];
    acc_vec[ACC_CNT_BIT]  = ch_busy[CH_CNT];
    acc_vec[ACC_SNAP_BIT] = ch_busy[CH_SNAP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= status[0] & ien_q;
      if (rd_en) begin
        case (addr)
          OFS_CMP:  rdata <= cmp_q;
          OFS_CNT:  rdata <= snap_q;
          OFS_STAT: rdata <= CW'(status);
          OFS_IEN:  rdata <= CW'(ien_q);
          OFS_CTL:  rdata <= CW'(run_q);
          OFS_ACC:  rdata <= acc_vec;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          ien_q,
  input logic          st0,
  input logic          run_q,
  input logic          tick_en,
  input logic          cnt_load,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cmp_q,
  input logic [CW-1:0] snap_q,
  input logic          cmp_busy,
  input logic          snap_busy
);
  // R5: compare value only moves at the end of its busy window
  p_cmp_commit_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_q != $past(cmp_q)) |-> $fell(cmp_busy));

  // R3: snapshot only moves at the end of its busy window
  p_snap_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (snap_q != $past(snap_q)) |-> $fell(snap_busy));

  // R9: all ones rolls to zero on an advancing tick
  p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_q) == '1 && $past(run_q) && $past(tick_en) && !$past(cnt_load))
      |-> (cnt_q == '0));

  // R2: counter holds when not running and not loading
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(run_q) && !$past(cnt_load)) |-> $stable(cnt_q));

  // R8: interrupt needs the enable
  p_irq_en_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien_q));

  // R7: cleared flag drops the interrupt on the next clock
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(st0) |=> !irq);
endmodule

bind match_timer match_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ien_q(ien_q), .st0(status[0]),
  .run_q(run_q), .tick_en(tick_en), .cnt_load(ch_done[1]),
  .cnt_q(cnt_q), .cmp_q(cmp_q), .snap_q(snap_q),
  .cmp_busy(ch_busy[0]), .snap_busy(ch_busy[2])
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        tick_en = 0, wr_en = 0, rd_en = 0, rd_chk = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) rd_pend <= rd_en & rd_chk;

  // monitor: compare registered read data against the queue
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; rd_chk = 1; addr = a;
    @(negedge clk);
    rd_en = 0; rd_chk = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50; i++) begin
      rd_en = 1; addr = 6'h24;
      @(negedge clk);
      rd_en = 0;
      @(negedge clk);
      if (rdata == 0) break;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1;
      @(negedge clk);
      tick_en = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1: reset values
    rd(6'h00, 32'hFFFFFFFF, "R1 cmp");
    rd(6'h10, 32'h0, "R1 snapshot");
    rd(6'h14, 32'h0, "R1 status");
    rd(6'h1C, 32'h0, "R1 enable");
    rd(6'h20, 32'h0, "R1 control");
    rd(6'h24, 32'h0, "R1 access");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    // R5: staged compare write
    wr(6'h00, 32'd100);
    rd(6'h24, 32'h1, "R5 cmp busy");
    rd(6'h00, 32'hFFFFFFFF, "R5 old value while busy");
    wait_idle();
    rd(6'h00, 32'd100, "R5 committed");
    // R4: staged count load
    wr(6'h10, 32'd90);
    rd(6'h24, 32'h10, "R4 count busy");
    wait_idle();
    // R3: snapshot request, sets run as well
    wr(6'h20, 32'h3);
    rd(6'h24, 32'h20, "R3 snap busy");
    wait_idle();
    rd(6'h10, 32'd90, "R3 R4 snapshot after load");
    rd(6'h20, 32'h1, "R2 control reads run");
    ticks(5);
    idle(2);
    rd(6'h10, 32'd90, "R3 snapshot not live");
    wr(6'h20, 32'h3);
    wait_idle();
    rd(6'h10, 32'd95, "R2 advanced by ticks");
    // R6 R8: reach match with enable off
    ticks(5);
    idle(3);
    rd(6'h14, 32'h1, "R6 match flag");
    chk("R8 irq gated off", {31'b0, irq}, 32'h0);
    wr(6'h14, 32'h0);
    idle(1);
    rd(6'h14, 32'h1, "R7 zero write keeps flag");
    wr(6'h1C, 32'h1);
    idle(2);
    chk("R8 irq on enable", {31'b0, irq}, 32'h1);
    wr(6'h14, 32'hF);
    idle(2);
    chk("R7 irq after clear", {31'b0, irq}, 32'h0);
    rd(6'h14, 32'h0, "R7 flag cleared");
    // R9: wrap without flag
    wr(6'h00, 32'd5);
    wait_idle();
    wr(6'h10, 32'hFFFFFFFE);
    wait_idle();
    ticks(2);
    idle(3);
    rd(6'h14, 32'h0, "R9 no flag on wrap");
    wr(6'h20, 32'h3);
    wait_idle();
    rd(6'h10, 32'h0, "R9 wrapped to zero");
    ticks(5);
    idle(3);
    rd(6'h14, 32'h1, "R6 match after wrap");
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    // R2: stop via latch-only write, counter holds
    wr(6'h20, 32'h2);
    wait_idle();
    ticks(3);
    wr(6'h20, 32'h2);
    wait_idle();
    rd(6'h10, 32'd5, "R2 hold when stopped");
    rd(6'h20, 32'h0, "R2 run cleared");
    // R10: unmapped
    rd(6'h08, 32'h0, "R10 unmapped");
    idle(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule